// File: doc/BRIEF.md
# Clear-on-Read Ring Notification Aggregator

This block gathers per-hop ring events of three kinds into one packed status vector and drives a single level interrupt. Each hop has three one-cycle event inputs: transmit done, receive done and receive overflow. Each pulse sets a sticky status bit. Software reads the status as 32-bit words, and every read clears the word it returns. A bank of enable words selects which hops may raise the interrupt. A read-only register reports the number of hops, which is a parameter.

After the interrupt fires it stays blocked until software has read every status word at least once. This includes words whose hops are all disabled. This keeps a handler from missing events packed into words it skipped. The three bitfields are packed end to end, so one hop's bits may fall in a different word from another's.

Register access is a plain address with a read strobe and a write strobe. Read data appears one cycle after the strobe.

Top module: `ringnote_agg`

## Requirements
- R1: After reset, irq is 0, all enable bits are 0, every status word reads 0, and the block is armed, so an enabled event can fire the interrupt without any prior read.
- R2: Status bit index for transmit-done of hop h is h, for receive-done is HOPS+h, and for receive overflow is 2*HOPS+h. Status word w, at word address w, holds bits 32w to 32w+31. There are (31+3*HOPS)/32 status words, and bits above 3*HOPS-1 read 0.
- R3: A read of a status word returns its value as it was before the read, in rdata on the next cycle, and clears that word. A second read of the same word returns 0 if no new event arrived.
- R4: An event that arrives in the same cycle as a read of its word is not part of that read's data. It stays pending and is returned by the next read.
- R5: Enable words start at word address 16, and there are (31+2*HOPS)/32 of them. Enable bit h is the receive enable of hop h, and it gates both receive-done and receive overflow. Enable bit HOPS+h is the transmit enable of hop h. Writes take effect on the next cycle and read back, and bits above 2*HOPS-1 read 0.
- R6: While armed and with irq low, irq rises one cycle after a status bit whose enable is set is pending. Events whose enable is clear never raise irq.
- R7: A read of status word 0 while irq is high drops irq on the next cycle.
- R8: When irq fires, the per-word read record is cleared. No new interrupt fires until every status word has been read once, including words that hold no enabled bits.
- R9: Word address 32 reads HOPS in bits 10:0 and 0 above, and writes to it have no effect. rdata is 0 in a cycle that follows no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_done | input | HOPS | Per-hop transmit-done event pulses |
| rx_done | input | HOPS | Per-hop receive-done event pulses |
| rx_ovf | input | HOPS | Per-hop receive-overflow event pulses |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that rd_en and wr_en only target addresses inside the mapped status, enable and count ranges. The stimulus draws addresses only from those ranges. They also assume that events are ordinary one-cycle pulses with no ordering rule between hops. The random phase draws sparse event pulses from all three kinds, together with reads and enable writes. Directed sequences force the cases the assertions single out: a read that collides with an event, the cross-word placement of high hops, and a blocked interrupt that is released by reading a word with no enabled bits.

// File: rtl/ringnote_pkg.sv
package ringnote_pkg;
   function automatic int words_for(input int bits_per_hop, input int hops);
      return (31 + bits_per_hop * hops) / 32;
   endfunction
   localparam int CNT_FIELD_W = 11;
endpackage

// File: rtl/rn_status_bank.sv
module rn_status_bank #(
   parameter int HOPS = 20,
   parameter int NSW  = 2,
   parameter int IW   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3*HOPS-1:0] evt_vec,
   input  logic              clr_en,
   input  logic [IW-1:0]     clr_idx,
   output logic [3*HOPS-1:0] pend,
   output logic [31:0]       rd_word
);
   localparam int NB   = 3 * HOPS;
   localparam int PADW = NSW * 32;

   logic [PADW-1:0] pend_pad;
   logic [PADW-1:0] clr_pad;

   assign pend_pad = PADW'(pend);

   for (genvar w = 0; w < NSW; w++) begin : g_word
      assign clr_pad[w*32 +: 32] = {32{clr_en && (clr_idx == IW'(w))}};

      a_r3_word_cleared: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_en && clr_idx == IW'(w) && evt_vec == '0) |=> (pend_pad[w*32 +: 32] == 32'h0));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~clr_pad[NB-1:0]) | evt_vec;
   end

   always_comb begin
      rd_word = 32'h0;
      for (int w = 0; w < NSW; w++)
         if (clr_idx == IW'(w)) rd_word = pend_pad[w*32 +: 32];
   end

   a_r4_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_vec) |=> ((pend & $past(evt_vec)) == $past(evt_vec)));
endmodule

// File: rtl/rn_enable_bank.sv
module rn_enable_bank #(
   parameter int HOPS = 20,
   parameter int NEW  = 2,
   parameter int IW   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [IW-1:0]     idx,
   input  logic [31:0]       wdata,
   output logic [2*HOPS-1:0] en,
   output logic [31:0]       rd_word
);
   localparam int PW = NEW * 32;
   localparam logic [PW-1:0] ONE   = PW'(1);
   localparam logic [PW-1:0] VMASK = (ONE << (2 * HOPS)) - ONE;

   logic [PW-1:0] en_pad;

   always_ff @(posedge clk) begin
      if (!rst_n) en_pad <= '0;
      else if (wr_hit) begin
         for (int w = 0; w < NEW; w++)
            if (idx == IW'(w)) en_pad[w*32 +: 32] <= wdata & VMASK[w*32 +: 32];
      end
   end

   always_comb begin
      rd_word = 32'h0;
      for (int w = 0; w < NEW; w++)
         if (idx == IW'(w)) rd_word = en_pad[w*32 +: 32];
   end

   assign en = en_pad[2*HOPS-1:0];

   a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && idx == '0) |=> (en_pad[31:0] == ($past(wdata) & VMASK[31:0])));
endmodule

// File: rtl/rn_irq_ctrl.sv
module rn_irq_ctrl #(
   parameter int NSW = 2,
   parameter int IW  = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pend_any,
   input  logic           rd_hit,
   input  logic [IW-1:0]  rd_idx,
   output logic           irq
);
   logic [NSW-1:0] seen;
   logic           armed;

   assign armed = &seen;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq  <= 1'b0;
         seen <= '1;
      end else if (!irq && armed && pend_any) begin
         irq  <= 1'b1;
         seen <= '0;
      end else begin
         if (rd_hit && rd_idx == '0) irq <= 1'b0;
         for (int w = 0; w < NSW; w++)
            if (rd_hit && rd_idx == IW'(w)) seen[w] <= 1'b1;
      end
   end

   a_r8_blocked_until_all_read: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !armed) |=> !irq);
   a_r8_record_cleared_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (seen == '0));
   a_r7_word0_drops_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && rd_hit && rd_idx == '0) |=> !irq);
endmodule

// File: rtl/ringnote_agg.sv
module ringnote_agg
   import ringnote_pkg::*;
#(
   parameter int HOPS     = 20,
   parameter int ADDR_W   = 6,
   parameter int EN_BASE  = 16,
   parameter int CNT_ADDR = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [HOPS-1:0]   tx_done,
   input  logic [HOPS-1:0]   rx_done,
   input  logic [HOPS-1:0]   rx_ovf,
   input  logic              rd_en,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [31:0]       wdata,
   output logic [31:0]       rdata,
   output logic              irq
);
   localparam int NSW = words_for(3, HOPS);
   localparam int NEW = words_for(2, HOPS);

   if (HOPS < 1 || HOPS >= (1 << CNT_FIELD_W)) begin : g_bad_hops
      $error("HOPS out of range for the count field");
   end
   if (NSW > EN_BASE || EN_BASE + NEW > CNT_ADDR || CNT_ADDR >= (1 << ADDR_W)) begin : g_bad_map
      $error("address map regions overlap or exceed ADDR_W");
   end

   logic              stat_sel, en_sel, cnt_sel;
   logic [ADDR_W-1:0] en_idx;
   logic [3*HOPS-1:0] evt_vec, pend, en_exp;
   logic [2*HOPS-1:0] en;
   logic [31:0]       stat_word, en_word, cnt_word;

   assign stat_sel = addr < ADDR_W'(NSW);
   assign en_sel   = (addr >= ADDR_W'(EN_BASE)) && (addr < ADDR_W'(EN_BASE + NEW));
   assign cnt_sel  = addr == ADDR_W'(CNT_ADDR);
   assign en_idx   = addr - ADDR_W'(EN_BASE);
   assign evt_vec  = {rx_ovf, rx_done, tx_done};
   assign cnt_word = 32'(HOPS);

   for (genvar h = 0; h < HOPS; h++) begin : g_hop
      assign en_exp[h]          = en[HOPS + h];
      assign en_exp[HOPS + h]   = en[h];
      assign en_exp[2*HOPS + h] = en[h];
   end

   rn_status_bank #(.HOPS(HOPS), .NSW(NSW), .IW(ADDR_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .evt_vec(evt_vec),
      .clr_en(rd_en && stat_sel), .clr_idx(addr),
      .pend(pend), .rd_word(stat_word));

   rn_enable_bank #(.HOPS(HOPS), .NEW(NEW), .IW(ADDR_W)) u_en (
      .clk(clk), .rst_n(rst_n), .wr_hit(wr_en && en_sel), .idx(en_idx),
      .wdata(wdata), .en(en), .rd_word(en_word));

   rn_irq_ctrl #(.NSW(NSW), .IW(ADDR_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .pend_any(|(pend & en_exp)),
      .rd_hit(rd_en && stat_sel), .rd_idx(addr), .irq(irq));

   always_ff @(posedge clk) begin
      if (!rst_n)                 rdata <= 32'h0;
      else if (rd_en && stat_sel) rdata <= stat_word;
      else if (rd_en && en_sel)   rdata <= en_word;
      else if (rd_en && cnt_sel)  rdata <= cnt_word;
      else                        rdata <= 32'h0;
   end

   a_r6_disabled_never_fires: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && ((pend & en_exp) == '0)) |=> !irq);
   a_r9_count_readout: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && cnt_sel) |=> (rdata == 32'(HOPS)));
   a_r9_idle_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> (rdata == 32'h0));
endmodule

// File: tb/tb_ringnote_agg.sv
module tb_ringnote_agg;
   localparam int H   = 20;
   localparam int NSW = (31 + 3*H) / 32;
   localparam int NEW = (31 + 2*H) / 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [H-1:0] tx_done = '0, rx_done = '0, rx_ovf = '0;
   logic rd_en = 1'b0, wr_en = 1'b0;
   logic [5:0] addr = '0;
   logic [31:0] wdata = '0, rdata;
   logic irq;

   always #2 clk = ~clk;

   ringnote_agg #(.HOPS(H)) dut (.clk(clk), .rst_n(rst_n), .tx_done(tx_done),
      .rx_done(rx_done), .rx_ovf(rx_ovf), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   logic [NSW*32-1:0] m_pend;
   logic [NEW*32-1:0] m_en;
   logic [NSW-1:0]    m_seen;
   logic              m_irq;
   logic [31:0]       m_rdata;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [3*H-1:0] expand(input logic [NEW*32-1:0] e);
      logic [3*H-1:0] x;
      for (int h = 0; h < H; h++) begin
         x[h] = e[H+h]; x[H+h] = e[h]; x[2*H+h] = e[h];
      end
      return x;
   endfunction

   function automatic logic [31:0] ref_read(input logic [5:0] a);
      if (a < 6'(NSW))                    return m_pend[a*32 +: 32];
      if (a >= 6'd16 && a < 6'(16 + NEW)) return m_en[(a-16)*32 +: 32];
      if (a == 6'd32)                     return 32'(H);
      return 32'h0;
   endfunction

   task automatic model_reset();
      m_pend = '0; m_en = '0; m_seen = '1; m_irq = 0; m_rdata = 0;
   endtask

   // one cycle: drive at negedge, advance the model at the edge, compare at the next negedge
   task automatic step(input logic [H-1:0] t, r, o, input logic rd, wr,
                       input logic [5:0] a, input logic [31:0] wd);
      logic [NSW*32-1:0] clr;
      logic fire;
      tx_done = t; rx_done = r; rx_ovf = o; rd_en = rd; wr_en = wr; addr = a; wdata = wd;
      @(posedge clk);
      clr  = '0;
      if (rd && a < 6'(NSW)) clr[a*32 +: 32] = '1;
      fire = !m_irq && (&m_seen) && (|(m_pend[3*H-1:0] & expand(m_en)));
      m_rdata = rd ? ref_read(a) : 32'h0;
      m_pend  = (m_pend & ~clr) | (NSW*32)'({o, r, t});
      if (fire) begin m_irq = 1; m_seen = '0; end
      else begin
         if (rd && a == 0) m_irq = 0;
         if (rd && a < 6'(NSW)) m_seen[a] = 1;
      end
      if (wr && a >= 6'd16 && a < 6'(16 + NEW))
         m_en[(a-16)*32 +: 32] = wd & (((NEW*32)'(1) << (2*H)) - 1) >> ((a-16)*32);
      @(negedge clk);
      chk("model irq R6 R7 R8", {31'h0, irq}, {31'h0, m_irq});
      chk("model rdata R2 R3 R5 R9", rdata, m_rdata);
      tx_done = '0; rx_done = '0; rx_ovf = '0; rd_en = 0; wr_en = 0;
   endtask

   task automatic idle(); step('0, '0, '0, 0, 0, 6'd0, 0); endtask
   task automatic rd(input logic [5:0] a); step('0, '0, '0, 1, 0, a, 0); endtask
   task automatic wr(input logic [5:0] a, input logic [31:0] d); step('0, '0, '0, 0, 1, a, d); endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #400000;
      if (!done) begin
         done = 1; n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      model_reset();
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      chk("R1 irq after reset", {31'h0, irq}, 32'h0);
      rd(0); chk("R1 status word0", rdata, 0);
      rd(1); chk("R1 status word1", rdata, 0);
      rd(16); chk("R1 enable word0", rdata, 0);
      rd(17); chk("R1 enable word1", rdata, 0);
      // R9 count register and write has no effect
      wr(32, 32'hFFFF_FFFF);
      rd(32); chk("R9 hop count", rdata, 32'd20);
      idle(); chk("R9 idle rdata", rdata, 0);
      // R2 packing across words, disabled events do not fire (R6)
      step(20'h00008, 20'h08000, 20'h80000, 0, 0, 0, 0);
      idle(); chk("R6 disabled no irq", {31'h0, irq}, 0);
      rd(0); chk("R2 word0 tx hop3", rdata, 32'h0000_0008);
      rd(1); chk("R2 word1 rx hop15 ovf hop19", rdata, 32'h0800_0008);
      rd(0); chk("R3 reread word0 clear", rdata, 0);
      rd(1); chk("R3 reread word1 clear", rdata, 0);
      // R4 event during read of its word
      step(20'h00002, '0, '0, 1, 0, 0, 0); chk("R4 read excludes collider", rdata, 0);
      rd(0); chk("R4 collider kept", rdata, 32'h0000_0002);
      // R5 enables, masked unused bits
      wr(17, 32'hFFFF_FFFF);
      rd(17); chk("R5 enable word1 mask", rdata, 32'h0000_00FF);
      wr(17, 0);
      wr(16, 32'h0000_0001);
      rd(16); chk("R5 enable word0", rdata, 32'h1);
      // R6 fire, R7 drop, R8 block and release
      step('0, 20'h00001, '0, 0, 0, 0, 0);
      chk("R6 not yet", {31'h0, irq}, 0);
      idle(); chk("R6 irq fires", {31'h0, irq}, 1);
      rd(0); chk("R7 irq dropped", {31'h0, irq}, 0);
      step('0, 20'h00001, '0, 0, 0, 0, 0);
      repeat (4) idle();
      chk("R8 blocked", {31'h0, irq}, 0);
      rd(1); chk("R8 still low at release read", {31'h0, irq}, 0);
      idle(); chk("R8 fires after all words read", {31'h0, irq}, 1);
      rd(0); rd(1);
      // overflow gated by receive enable (R5)
      step('0, '0, 20'h00001, 0, 0, 0, 0);
      idle(); chk("R5 overflow gated by rx enable", {31'h0, irq}, 1);
      rd(0); rd(1);
      // random phase
      for (int i = 0; i < 600; i++) begin
         logic [H-1:0] t, r, o;
         logic [5:0] a;
         int k;
         t = ($urandom % 8 == 0) ? H'(1 << ($urandom % H)) : '0;
         r = ($urandom % 8 == 0) ? H'(1 << ($urandom % H)) : '0;
         o = ($urandom % 16 == 0) ? H'(1 << ($urandom % H)) : '0;
         k = $urandom % 10;
         case ($urandom % 5)
            0: a = 0; 1: a = 1; 2: a = 16; 3: a = 17; default: a = 32;
         endcase
         if (k < 4)       step(t, r, o, 1, 0, a, 0);
         else if (k == 4) step(t, r, o, 0, 1, (a == 16 || a == 17) ? a : 6'd16, $urandom);
         else             step(t, r, o, 0, 0, 0, 0);
      end
      done = 1;
      summary();
   end
endmodule